// File: doc/BRIEF.md
# I2C Target Byte Engine

This block moves data bytes for an I2C target once the target has been addressed. Address matching and START/STOP detection are done elsewhere. That logic reports the outcome through a selected level (`sel_i`) and a direction level (`rnw_i`, 1 when the controller reads).

The engine samples both bus lines through a two-flop synchronizer and finds SCL edges in the system clock domain. It drives each line only by pulling it low through an output enable.

- **Controller reads:** bytes go out MSB first from a transmit holding register. A transmit-valid bit tracks whether software has supplied a fresh byte. Depending on `stretch_en_i`, a missing byte is either waited for by holding SCL low, or replaced by the old register contents with an underflow report.
- **Controller writes:** bytes are assembled MSB first, copied to a receive register and acknowledged.

Four sticky flags report what happened: receive-ready, transmit underflow, controller NAK and SDA contention. Each flag has an interrupt enable. Software clears them by reading the receive register or by write-one-to-clear.

Top module: `i2ct_byte_engine`

## Requirements
- R1: On a controller read, each data bit is placed on SDA while SCL is low, MSB first, and stays in place for one SCL cycle. SDA is released during the ninth (acknowledge) clock, and `sda_oe_o` changes only while the synchronized SCL is low.
- R2: On a controller write, eight bits are shifted in MSB first on SCL rising edges. On the eighth rising edge the byte is copied to `rx_rdata_o` and `stat_o[0]` (receive-ready) is set. The target pulls SDA low (ACK) for the ninth clock.
- R3: `stat_o[0]` clears on the cycle after an `rx_rd_i` pulse, unless a new byte arrives in that same cycle. A status write has no effect on it.
- R4: A write to the transmit register sets a valid bit. The byte is loaded into the shifter at selection, or after an ACK in the ninth clock, and loading clears the valid bit. A byte written during a byte in progress is therefore sent next.
- R5: With `stretch_en_i` = 1 and no valid byte at a load point, `scl_oe_o` is held high (SCL low) until the transmit register is written. It is released three cycles after that write, one cycle after the first bit is driven.
- R6: A NAK (SDA high in the ninth clock) sets `stat_o[2]`. After a NAK the engine neither stretches SCL nor drives SDA until it is deselected.
- R7: With `stretch_en_i` = 0 and no valid byte at a load point, the previous transmit register contents are sent again and `stat_o[1]` (underflow) is set. No underflow is flagged when a valid byte was present.
- R8: On each SCL rising edge of a transmitted data bit, the sampled SDA is compared with the intended bit. Any difference sets `stat_o[3]`.
- R9: Writing 1 to bit k of `stat_wdata_i` (k = 1..3) with `stat_wr_i` clears `stat_o[k]`. A 0 leaves the flag unchanged. A flag being set in the same cycle wins over the clear.
- R10: `irq_o` is 1 exactly when some `stat_o[k]` and `irq_en_i[k]` are both 1.
- R11: After reset `scl_oe_o`, `sda_oe_o`, `stat_o`, `irq_o` and `rx_rdata_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| sel_i | input | 1 | Target is addressed |
| rnw_i | input | 1 | 1 = controller reads, 0 = controller writes |
| stretch_en_i | input | 1 | Enable clock stretching when transmit data is missing |
| tx_wr_i | input | 1 | Transmit register write strobe |
| tx_wdata_i | input | DW | Transmit byte |
| rx_rd_i | input | 1 | Receive register read strobe |
| rx_rdata_o | output | DW | Last received byte |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 3 | Write-one-to-clear mask for flags 3..1 |
| irq_en_i | input | 4 | Interrupt enable per flag |
| stat_o | output | 4 | Flags: 0 rx-ready, 1 underflow, 2 NAK, 3 mismatch |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle, the embedded properties check the following:
- SDA drive only moves while SCL is low.
- Reading the receive register or writing one to a flag really empties that flag.
- A transmit write ends a stretch within three cycles.
- A NAK in the ninth clock is never followed by stretching.

The directed scenarios are the only way to show the byte-level results:
- Bit order on both directions.
- Which byte goes out after an ACK.
- The stale byte being resent when data is missing.
- Contention detection with a controller that fights the line.
- The interrupt gating by enables.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int NFLAG = 4;
  localparam int F_RX  = 0;
  localparam int F_UF  = 1;
  localparam int F_NAK = 2;
  localparam int F_MIS = 3;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOAD,
    PH_SHIFT,
    PH_DONE
  } ph_e;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int              W       = 2,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // STAGES must be at least 2
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_n;

  always_comb begin
    stg_n = {stg_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_n;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2ct_txbuf.sv
module i2ct_txbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          take_i,
  output logic [DW-1:0] data_o,
  output logic          vld_o
);
  logic [DW-1:0] data_q, data_n;
  logic          vld_q, vld_n;

  always_comb begin
    data_n = data_q;
    vld_n  = vld_q;
    if (take_i) vld_n = 1'b0;
    if (wr_i) begin
      data_n = wdata_i;
      vld_n  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      data_q <= data_n;
      vld_q  <= vld_n;
    end
  end

  assign data_o = data_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/i2ct_xfer.sv
module i2ct_xfer
  import i2ct_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_i,
  input  logic          rnw_i,
  input  logic          stretch_en_i,
  input  logic          scl_s_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          sda_s_i,
  input  logic          tx_vld_i,
  input  logic [DW-1:0] tx_data_i,
  output logic          tx_take_o,
  output logic [DW-1:0] rx_data_o,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  output logic          ev_rx_o,
  output logic          ev_uf_o,
  output logic          ev_nak_o,
  output logic          ev_mis_o
);
  localparam int            CW    = $clog2(DW + 1);
  localparam logic [CW-1:0] ACKB  = CW'(DW);
  localparam logic [CW-1:0] LASTD = CW'(DW - 1);

  ph_e           ph_q, ph_n;
  logic [CW-1:0] bitn_q, bitn_n;
  logic [DW-1:0] sh_q, sh_n;
  logic [DW-1:0] rx_q, rx_n;
  logic          nak_q, nak_n;
  logic          str_q, str_n;

  always_comb begin
    ph_n      = ph_q;
    bitn_n    = bitn_q;
    sh_n      = sh_q;
    rx_n      = rx_q;
    nak_n     = nak_q;
    tx_take_o = 1'b0;
    ev_rx_o   = 1'b0;
    ev_uf_o   = 1'b0;
    ev_nak_o  = 1'b0;
    ev_mis_o  = 1'b0;
    if (!sel_i) begin
      ph_n   = PH_IDLE;
      bitn_n = '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          bitn_n = '0;
          nak_n  = 1'b0;
          ph_n   = rnw_i ? PH_LOAD : PH_SHIFT;
        end
        PH_LOAD: begin
          bitn_n = '0;
          if (tx_vld_i) begin
            sh_n      = tx_data_i;
            tx_take_o = 1'b1;
            ph_n      = PH_SHIFT;
          end else if (!stretch_en_i) begin
            sh_n    = tx_data_i;
            ev_uf_o = 1'b1;
            ph_n    = PH_SHIFT;
          end
        end
        PH_SHIFT: begin
          if (scl_rise_i) begin
            if (bitn_q == ACKB) begin
              if (rnw_i) begin
                nak_n    = sda_s_i;
                ev_nak_o = sda_s_i;
              end
            end else if (rnw_i) begin
              ev_mis_o = (sda_s_i != sh_q[DW-1]);
            end else begin
              sh_n = {sh_q[DW-2:0], sda_s_i};
              if (bitn_q == LASTD) begin
                rx_n    = {sh_q[DW-2:0], sda_s_i};
                ev_rx_o = 1'b1;
              end
            end
          end
          if (scl_fall_i) begin
            if (bitn_q == ACKB) begin
              bitn_n = '0;
              if (rnw_i) ph_n = nak_q ? PH_DONE : PH_LOAD;
            end else begin
              bitn_n = bitn_q + CW'(1);
              if (rnw_i) sh_n = {sh_q[DW-2:0], 1'b0};
            end
          end
        end
        default: ph_n = PH_DONE;
      endcase
    end
    // stretch stays one cycle past the load so SDA settles before SCL rises
    str_n = sel_i && (ph_q == PH_LOAD) && (str_q || (stretch_en_i && !tx_vld_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      bitn_q <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      nak_q  <= 1'b0;
      str_q  <= 1'b0;
    end else begin
      ph_q   <= ph_n;
      bitn_q <= bitn_n;
      sh_q   <= sh_n;
      rx_q   <= rx_n;
      nak_q  <= nak_n;
      str_q  <= str_n;
    end
  end

  assign scl_oe_o  = str_q;
  assign rx_data_o = rx_q;
  assign sda_oe_o  = sel_i && (ph_q == PH_SHIFT) &&
                     (rnw_i ? ((bitn_q != ACKB) && !sh_q[DW-1]) : (bitn_q == ACKB));

  // R1
  sda_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && $past(sel_i) && (sda_oe_o != $past(sda_oe_o))) |-> !scl_s_i);

  // R6
  nak_nostretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && rnw_i && scl_fall_i && (ph_q == PH_SHIFT) && (bitn_q == ACKB) && nak_q)
      |=> ##2 !scl_oe_o);
endmodule

// File: rtl/i2ct_flags.sv
module i2ct_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    logic f_q, f_n;

    always_comb begin
      f_n = set_i[k] | (f_q & ~clr_i[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) f_q <= 1'b0;
      else        f_q <= f_n;
    end

    assign flags_o[k] = f_q;

    // R9
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[k] && !set_i[k]) |=> !flags_o[k]);
  end

  assign irq_o = |(flags_o & en_i);
endmodule

// File: rtl/i2ct_byte_engine.sv
module i2ct_byte_engine
  import i2ct_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  input  logic             sel_i,
  input  logic             rnw_i,
  input  logic             stretch_en_i,
  input  logic             tx_wr_i,
  input  logic [DW-1:0]    tx_wdata_i,
  input  logic             rx_rd_i,
  output logic [DW-1:0]    rx_rdata_o,
  input  logic             stat_wr_i,
  input  logic [NFLAG-1:1] stat_wdata_i,
  input  logic [NFLAG-1:0] irq_en_i,
  output logic [NFLAG-1:0] stat_o,
  output logic             irq_o
);
  logic [1:0]       rst_sq;
  logic             rst_ni;
  logic [1:0]       lines_s;
  logic             scl_s, sda_s, scl_d_q;
  logic             scl_rise, scl_fall;
  logic [DW-1:0]    tx_data;
  logic             tx_vld, tx_take;
  logic             ev_rx, ev_uf, ev_nak, ev_mis;
  logic [NFLAG-1:0] fset, fclr;

  // reset asserts at once and leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_ni = rst_sq[1];

  i2ct_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) scl_d_q <= 1'b1;
    else         scl_d_q <= scl_s;
  end
  assign scl_rise = scl_s & ~scl_d_q;
  assign scl_fall = ~scl_s & scl_d_q;

  i2ct_txbuf #(.DW(DW)) u_txbuf (
    .clk     (clk),
    .rst_n   (rst_ni),
    .wr_i    (tx_wr_i),
    .wdata_i (tx_wdata_i),
    .take_i  (tx_take),
    .data_o  (tx_data),
    .vld_o   (tx_vld)
  );

  i2ct_xfer #(.DW(DW)) u_xfer (
    .clk          (clk),
    .rst_n        (rst_ni),
    .sel_i        (sel_i),
    .rnw_i        (rnw_i),
    .stretch_en_i (stretch_en_i),
    .scl_s_i      (scl_s),
    .scl_rise_i   (scl_rise),
    .scl_fall_i   (scl_fall),
    .sda_s_i      (sda_s),
    .tx_vld_i     (tx_vld),
    .tx_data_i    (tx_data),
    .tx_take_o    (tx_take),
    .rx_data_o    (rx_rdata_o),
    .scl_oe_o     (scl_oe_o),
    .sda_oe_o     (sda_oe_o),
    .ev_rx_o      (ev_rx),
    .ev_uf_o      (ev_uf),
    .ev_nak_o     (ev_nak),
    .ev_mis_o     (ev_mis)
  );

  always_comb begin
    fset         = '0;
    fset[F_RX]   = ev_rx;
    fset[F_UF]   = ev_uf;
    fset[F_NAK]  = ev_nak;
    fset[F_MIS]  = ev_mis;
    fclr         = '0;
    fclr[F_RX]   = rx_rd_i;
    fclr[NFLAG-1:1] = stat_wdata_i & {(NFLAG-1){stat_wr_i}};
  end

  i2ct_flags #(.N(NFLAG)) u_flags (
    .clk     (clk),
    .rst_n   (rst_ni),
    .set_i   (fset),
    .clr_i   (fclr),
    .en_i    (irq_en_i),
    .flags_o (stat_o),
    .irq_o   (irq_o)
  );

  // R3
  rxrd_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (rx_rd_i && !ev_rx) |=> !stat_o[F_RX]);

  // R5
  stretch_release_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (tx_wr_i && scl_oe_o) |=> ##2 !scl_oe_o);
endmodule

// File: tb/i2ct_byte_engine_tb.sv
`timescale 1ns/1ps
module i2ct_byte_engine_tb;
  logic       clk, rst_n;
  logic       scl_m, sda_m, scl_line, sda_line;
  logic       scl_oe, sda_oe, sel, rnw, str_en;
  logic       tx_wr, rx_rd, stat_wr, irq;
  logic [7:0] tx_wdata, rx_rdata;
  logic [3:1] stat_wdata;
  logic [3:0] irq_en, stat;
  int         nvec, nerr;

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  i2ct_byte_engine u_dut (
    .clk (clk), .rst_n (rst_n), .scl_i (scl_line), .sda_i (sda_line),
    .scl_oe_o (scl_oe), .sda_oe_o (sda_oe), .sel_i (sel), .rnw_i (rnw),
    .stretch_en_i (str_en), .tx_wr_i (tx_wr), .tx_wdata_i (tx_wdata),
    .rx_rd_i (rx_rd), .rx_rdata_o (rx_rdata), .stat_wr_i (stat_wr),
    .stat_wdata_i (stat_wdata), .irq_en_i (irq_en), .stat_o (stat), .irq_o (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tx_write(input logic [7:0] b);
    @(negedge clk); tx_wr = 1'b1; tx_wdata = b;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic stat_clear(input logic [3:1] m);
    @(negedge clk); stat_wr = 1'b1; stat_wdata = m;
    @(negedge clk); stat_wr = 1'b0; stat_wdata = '0;
    idle(1);
  endtask

  task automatic rx_read();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
    idle(1);
  endtask

  task automatic clk_bit(input logic v, output logic b);
    sda_m = v;
    idle(10);
    scl_m = 1'b1;
    while (!scl_line) @(negedge clk);
    idle(10);
    b = sda_line;
    scl_m = 1'b0;
    idle(10);
  endtask

  task automatic select(input logic dir);
    scl_m = 1'b0;
    idle(10);
    rnw = dir;
    sel = 1'b1;
    idle(10);
  endtask

  task automatic deselect();
    sel = 1'b0;
    idle(4);
    sda_m = 1'b1;
    scl_m = 1'b1;
    idle(10);
  endtask

  task automatic read_byte(output logic [7:0] d, input logic ackv);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, b);
      d[i] = b;
    end
    idle(5);
    check("R1 sda released in ninth clock", sda_oe, 1'b0);
    clk_bit(ackv, b);
  endtask

  task automatic write_byte(input logic [7:0] d, output logic ackb);
    logic b;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], b);
    clk_bit(1'b1, ackb);
  endtask

  task automatic t_reset();
    check("R11 scl_oe", scl_oe, 1'b0);
    check("R11 sda_oe", sda_oe, 1'b0);
    check("R11 stat", stat, 4'h0);
    check("R11 irq", irq, 1'b0);
    check("R11 rx_rdata", rx_rdata, 8'h00);
  endtask

  task automatic t_read_ack_nak();
    logic [7:0] d;
    logic       b;
    str_en = 1'b0;
    tx_write(8'hB4);
    select(1'b1);
    tx_write(8'h1E);
    read_byte(d, 1'b0);
    check("R1 first byte msb first", d, 8'hB4);
    read_byte(d, 1'b1);
    check("R4 byte written during transfer sent after ACK", d, 8'h1E);
    check("R7 no underflow with valid data", stat[1], 1'b0);
    check("R8 no mismatch on clean bus", stat[3], 1'b0);
    check("R6 nak flag set", stat[2], 1'b1);
    clk_bit(1'b1, b);
    check("R6 sda idle after nak", b, 1'b1);
    check("R6 no stretch after nak", scl_oe, 1'b0);
    deselect();
    stat_clear(3'b000);
    check("R9 zero write keeps flag", stat[2], 1'b1);
    stat_clear(3'b010);
    check("R9 one write clears nak", stat[2], 1'b0);
  endtask

  task automatic t_underflow();
    logic [7:0] d;
    str_en = 1'b0;
    tx_write(8'h96);
    select(1'b1);
    read_byte(d, 1'b0);
    check("R4 preloaded byte", d, 8'h96);
    read_byte(d, 1'b1);
    check("R7 stale byte resent", d, 8'h96);
    check("R7 underflow flag", stat[1], 1'b1);
    irq_en = 4'b0010;
    idle(1);
    check("R10 irq on enabled underflow", irq, 1'b1);
    irq_en = 4'b1000;
    idle(1);
    check("R10 irq masked", irq, 1'b0);
    irq_en = 4'b0000;
    deselect();
    stat_clear(3'b011);
    check("R9 clear underflow and nak", stat, 4'h0);
  endtask

  task automatic t_stretch();
    logic [7:0] d;
    str_en = 1'b1;
    select(1'b1);
    fork
      begin
        idle(60);
        check("R5 stretch at selection", scl_oe, 1'b1);
        check("R5 scl held low", scl_line, 1'b0);
        tx_write(8'h5A);
        idle(4);
        check("R5 stretch released after write", scl_oe, 1'b0);
      end
      read_byte(d, 1'b0);
    join
    check("R5 byte after stretch", d, 8'h5A);
    fork
      begin
        idle(60);
        check("R5 stretch after ACK", scl_oe, 1'b1);
        tx_write(8'h11);
      end
      read_byte(d, 1'b1);
    join
    check("R5 second stretched byte", d, 8'h11);
    idle(20);
    check("R6 nak does not stretch", scl_oe, 1'b0);
    check("R7 no underflow while stretching", stat[1], 1'b0);
    deselect();
    stat_clear(3'b010);
    str_en = 1'b0;
  endtask

  task automatic t_mismatch();
    logic b;
    tx_write(8'hFF);
    select(1'b1);
    for (int i = 7; i >= 0; i--) clk_bit((i == 3) ? 1'b0 : 1'b1, b);
    idle(5);
    clk_bit(1'b1, b);
    check("R8 mismatch flag", stat[3], 1'b1);
    irq_en = 4'b1000;
    idle(1);
    check("R10 irq on mismatch", irq, 1'b1);
    irq_en = 4'b0000;
    deselect();
    stat_clear(3'b110);
    check("R9 mismatch cleared", stat[3], 1'b0);
  endtask

  task automatic t_receive();
    logic ack;
    select(1'b0);
    write_byte(8'hC6, ack);
    check("R2 target ACK", ack, 1'b0);
    check("R2 rx data", rx_rdata, 8'hC6);
    check("R2 rx ready", stat[0], 1'b1);
    irq_en = 4'b0001;
    idle(1);
    check("R10 irq on rx ready", irq, 1'b1);
    irq_en = 4'b0000;
    stat_clear(3'b111);
    check("R3 status write keeps rx ready", stat[0], 1'b1);
    rx_read();
    check("R3 read clears rx ready", stat[0], 1'b0);
    write_byte(8'h5E, ack);
    check("R2 second ACK", ack, 1'b0);
    check("R2 second rx data", rx_rdata, 8'h5E);
    deselect();
    rx_read();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    nvec = 0; nerr = 0;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; sel = 1'b0; rnw = 1'b0;
    str_en = 1'b0; tx_wr = 1'b0; tx_wdata = '0; rx_rd = 1'b0;
    stat_wr = 1'b0; stat_wdata = '0; irq_en = '0;
    idle(5);
    rst_n = 1'b1;
    idle(5);
    t_reset();
    t_read_ack_nak();
    t_underflow();
    t_stretch();
    t_mismatch();
    t_receive();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule